// File: doc/BRIEF.md
# Way-Partitioned Victim Selector

This block chooses which way of one cache set receives a new line when a fill arrives. Every requester has its own way mask: one mask per core, and one shared mask for all non-core hardware agents. A mask bit of 0 lets that requester evict from the way. A mask bit of 1 forbids eviction from that way. The masks only limit replacement. Lookups may still hit in any way, and they never pass through this block.

On a fill request, the block takes the requester's mask together with the per-way valid, dirty, locked and use bits read from the tag array. One cycle later it reports the victim way, a flag saying the victim must be written back first, and a flag saying no way may be replaced. When the use bits of every candidate are already set, the block also reports which use bits the tag array must clear, so the approximate least-recently-used scheme can start over. Software writes and reads the masks through a small register port. A write that would forbid every way is discarded.

Top module: `victim_sel`

## Requirements
- R1: After reset every mask reads back as all zeros (every way allowed), and `vic_valid`, `vic_way`, `vic_none`, `vic_wb` and `vic_use_clr` are all zero.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored as the mask of requester `cfg_sel`. `cfg_rdata` always shows the stored mask of `cfg_sel` with no delay. A requester index of `NUM_CORES` or above selects the single shared mask of the non-core agents, and the same rule applies to `fill_id`.
- R3: A mask write whose data has every bit set is discarded, and the previous mask of that requester stays in place.
- R4: The chosen way always has a 0 bit in the mask of the requester that asked for the fill. A way whose bit is 1 is never chosen for that requester.
- R5: A way whose lock bit is set is never chosen.
- R6: Candidates are the ways that are allowed by the mask and not locked. If any candidate is invalid, the lowest-numbered invalid candidate is chosen.
- R7: If every candidate is valid, the lowest-numbered candidate with its use bit clear is chosen.
- R8: If every candidate is valid and has its use bit set, the lowest-numbered candidate is chosen. In that case `vic_use_clr` has a 1 for every candidate way. In all other cases `vic_use_clr` is zero.
- R9: If there is no candidate, `vic_none` is 1 and `vic_way`, `vic_wb` and `vic_use_clr` are zero.
- R10: All victim outputs are registered. `vic_valid` is high in exactly the cycle after a cycle with `fill_req` high. In a cycle after one with no request, every victim output is zero.
- R11: `vic_wb` is 1 exactly when a way was chosen and that way's line was both valid and dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | REQ_W | Requester whose mask is written or read |
| cfg_wdata | input | NUM_WAYS | Mask write data, 1 forbids eviction from a way |
| cfg_rdata | output | NUM_WAYS | Stored mask of `cfg_sel` |
| fill_req | input | 1 | Fill needs a victim this cycle |
| fill_id | input | REQ_W | Requesting agent |
| way_valid | input | NUM_WAYS | Valid bit of each way in the set |
| way_dirty | input | NUM_WAYS | Dirty bit of each way |
| way_lock | input | NUM_WAYS | Lock bit of each way |
| way_use | input | NUM_WAYS | Use bit of each way |
| vic_valid | output | 1 | Result of the previous cycle's request |
| vic_way | output | WAY_W | Chosen way |
| vic_wb | output | 1 | Chosen line must be written back |
| vic_none | output | 1 | No way may be replaced, the fill must not allocate |
| vic_use_clr | output | NUM_WAYS | Use bits the tag array must clear |

## Verification
The bench uses the default build: eight ways and four cores. The requester index is therefore three bits wide, and the index values 4 to 7 all select the shared agent mask, so the mapping of those extra codes is tested. With eight ways, a mask can allow a few ways and forbid the rest in many different ways. It can also lock every allowed way, or set the use bit on every candidate while other ways stay clear. A random phase mixes mask writes, including some with all bits set, with fills. A behavioural model compares every output on every clock.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    localparam int MAX_WAYS = 32;
    localparam int IDX_W    = 5;

    // Index of the least significant set bit, zero when none is set.
    function automatic logic [IDX_W-1:0] lowest_idx(input logic [MAX_WAYS-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = MAX_WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vsel_mask_bank.sv
module vsel_mask_bank #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    localparam int NUM_REQ  = NUM_CORES + 1,
    localparam int REQ_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REQ_W-1:0]    wr_sel,
    input  logic [NUM_WAYS-1:0] wr_data,
    input  logic [REQ_W-1:0]    rd_sel_a,
    output logic [NUM_WAYS-1:0] rd_mask_a,
    input  logic [REQ_W-1:0]    rd_sel_b,
    output logic [NUM_WAYS-1:0] rd_mask_b
);
    typedef logic [NUM_WAYS-1:0] mask_t;

    mask_t masks_d [NUM_REQ];
    mask_t masks_q [NUM_REQ];

    // Any index at or beyond the core count folds onto the agent entry.
    function automatic logic [REQ_W-1:0] fold(input logic [REQ_W-1:0] s);
        return (int'(s) >= NUM_CORES) ? REQ_W'(NUM_CORES) : s;
    endfunction

    logic [REQ_W-1:0] wr_idx;
    logic             wr_legal;

    always_comb begin
        wr_idx   = fold(wr_sel);
        wr_legal = wr_en && !(&wr_data);
        for (int i = 0; i < NUM_REQ; i++) begin
            masks_d[i] = masks_q[i];
            if (wr_legal && int'(wr_idx) == i) masks_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REQ; i++) masks_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REQ; i++) masks_q[i] <= masks_d[i];
        end
    end

    assign rd_mask_a = masks_q[fold(rd_sel_a)];
    assign rd_mask_b = masks_q[fold(rd_sel_b)];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_chk
        p_full_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(fold(wr_sel)) == g && (&wr_data)) |=> $stable(masks_q[g]))
            else $error("R3 full mask accepted");
        p_write_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(fold(wr_sel)) == g && !(&wr_data)) |=> masks_q[g] == $past(wr_data))
            else $error("R2 mask write lost");
    end
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
    import vsel_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] forbid,
    input  logic [NUM_WAYS-1:0] valid,
    input  logic [NUM_WAYS-1:0] dirty,
    input  logic [NUM_WAYS-1:0] lock,
    input  logic [NUM_WAYS-1:0] use_bits,
    output logic [WAY_W-1:0]    way,
    output logic                none,
    output logic                wb,
    output logic [NUM_WAYS-1:0] use_clr
);
    logic [NUM_WAYS-1:0] cand, empty, fresh;

    always_comb begin
        cand    = ~forbid & ~lock;
        empty   = cand & ~valid;
        fresh   = cand & valid & ~use_bits;
        way     = '0;
        none    = 1'b0;
        use_clr = '0;
        if (|empty) begin
            way = WAY_W'(lowest_idx(MAX_WAYS'(empty)));
        end else if (|fresh) begin
            way = WAY_W'(lowest_idx(MAX_WAYS'(fresh)));
        end else if (|cand) begin
            way     = WAY_W'(lowest_idx(MAX_WAYS'(cand)));
            use_clr = cand;
        end else begin
            none = 1'b1;
        end
        wb = !none && valid[way] && dirty[way];
    end
endmodule

// File: rtl/victim_sel.sv
module victim_sel #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    localparam int NUM_REQ  = NUM_CORES + 1,
    localparam int REQ_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REQ_W-1:0]    cfg_sel,
    input  logic [NUM_WAYS-1:0] cfg_wdata,
    output logic [NUM_WAYS-1:0] cfg_rdata,
    input  logic                fill_req,
    input  logic [REQ_W-1:0]    fill_id,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_dirty,
    input  logic [NUM_WAYS-1:0] way_lock,
    input  logic [NUM_WAYS-1:0] way_use,
    output logic                vic_valid,
    output logic [WAY_W-1:0]    vic_way,
    output logic                vic_wb,
    output logic                vic_none,
    output logic [NUM_WAYS-1:0] vic_use_clr
);
    typedef struct packed {
        logic                vld;
        logic [WAY_W-1:0]    way;
        logic                wb;
        logic                none;
        logic [NUM_WAYS-1:0] clr;
    } res_t;

    res_t res_d, res_q;

    logic [NUM_WAYS-1:0] fill_mask;
    logic [WAY_W-1:0]    pk_way;
    logic                pk_none, pk_wb;
    logic [NUM_WAYS-1:0] pk_clr;

    vsel_mask_bank #(.NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES)) u_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .rd_sel_a  (cfg_sel),
        .rd_mask_a (cfg_rdata),
        .rd_sel_b  (fill_id),
        .rd_mask_b (fill_mask)
    );

    vsel_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .forbid   (fill_mask),
        .valid    (way_valid),
        .dirty    (way_dirty),
        .lock     (way_lock),
        .use_bits (way_use),
        .way      (pk_way),
        .none     (pk_none),
        .wb       (pk_wb),
        .use_clr  (pk_clr)
    );

    always_comb begin
        res_d = '0;
        if (fill_req) begin
            res_d.vld  = 1'b1;
            res_d.way  = pk_way;
            res_d.wb   = pk_wb;
            res_d.none = pk_none;
            res_d.clr  = pk_clr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vic_valid   = res_q.vld;
    assign vic_way     = res_q.way;
    assign vic_wb      = res_q.wb;
    assign vic_none    = res_q.none;
    assign vic_use_clr = res_q.clr;

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> vic_valid) else $error("R10 missing result");
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> (!vic_valid && !vic_none && !vic_wb && vic_use_clr == '0 && vic_way == '0))
        else $error("R10 stray result");
    p_not_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && !vic_none) |-> (($past(way_lock) & (NUM_WAYS'(1) << vic_way)) == '0))
        else $error("R5 locked way chosen");
    p_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !cfg_we) |=> (vic_none || ((($past(fill_mask)) & (NUM_WAYS'(1) << vic_way)) == '0)))
        else $error("R4 forbidden way chosen");
    p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vic_none |-> (!vic_wb && vic_way == '0 && vic_use_clr == '0))
        else $error("R9 outputs not quiet");
    p_clr_has_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|vic_use_clr) |-> ((vic_use_clr & (NUM_WAYS'(1) << vic_way)) != '0))
        else $error("R8 victim outside clear set");
    p_wb_dirty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vic_wb |-> (($past(way_valid & way_dirty) & (NUM_WAYS'(1) << vic_way)) != '0))
        else $error("R11 writeback of clean line");
endmodule

// File: tb/victim_sel_bench.sv
`timescale 1ns/1ps
module victim_sel_bench;
    localparam int NW = 8;
    localparam int NC = 4;
    localparam int RW = 3;
    localparam int WW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_sel = '0;
    logic [NW-1:0] cfg_wdata = '0;
    logic [NW-1:0] cfg_rdata;
    logic          fill_req = 1'b0;
    logic [RW-1:0] fill_id = '0;
    logic [NW-1:0] way_valid = '0, way_dirty = '0, way_lock = '0, way_use = '0;
    logic          vic_valid, vic_wb, vic_none;
    logic [WW-1:0] vic_way;
    logic [NW-1:0] vic_use_clr;

    victim_sel u_victim_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fill_req(fill_req),
        .fill_id(fill_id), .way_valid(way_valid), .way_dirty(way_dirty),
        .way_lock(way_lock), .way_use(way_use), .vic_valid(vic_valid),
        .vic_way(vic_way), .vic_wb(vic_wb), .vic_none(vic_none),
        .vic_use_clr(vic_use_clr)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string tag    = "R1";

    // Reference state
    logic [NW-1:0] m_mask [NC+1];
    logic          e_vld, e_wb, e_none;
    int            e_way;
    logic [NW-1:0] e_clr;

    function automatic int slot(input int s);
        return (s >= NC) ? NC : s;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i <= NC; i++) m_mask[i] = '0;
            e_vld = 0; e_wb = 0; e_none = 0; e_way = 0; e_clr = '0;
        end else begin
            e_vld = 0; e_wb = 0; e_none = 0; e_way = 0; e_clr = '0;
            if (fill_req) begin
                int pick;
                logic [NW-1:0] mk;
                pick = -1;
                mk = m_mask[slot(int'(fill_id))];
                e_vld = 1;
                for (int w = 0; w < NW; w++)
                    if (pick < 0 && !mk[w] && !way_lock[w] && !way_valid[w]) pick = w;
                for (int w = 0; w < NW; w++)
                    if (pick < 0 && !mk[w] && !way_lock[w] && !way_use[w]) pick = w;
                if (pick < 0) begin
                    for (int w = NW - 1; w >= 0; w--)
                        if (!mk[w] && !way_lock[w]) begin
                            pick = w;
                            e_clr[w] = 1'b1;
                        end
                end
                if (pick < 0) e_none = 1;
                else begin
                    e_way = pick;
                    e_wb  = way_valid[pick] && way_dirty[pick];
                end
            end
            if (cfg_we && cfg_wdata != '1) m_mask[slot(int'(cfg_sel))] = cfg_wdata;
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cycles > 2) begin
            cmp("vic_valid",   int'(vic_valid), int'(e_vld));
            cmp("vic_way",     int'(vic_way),   e_way);
            cmp("vic_none",    int'(vic_none),  int'(e_none));
            cmp("vic_wb",      int'(vic_wb),    int'(e_wb));
            cmp("vic_use_clr", int'(vic_use_clr), int'(e_clr));
            cmp("cfg_rdata",   int'(cfg_rdata), int'(m_mask[slot(int'(cfg_sel))]));
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input int sel, input logic [NW-1:0] d, input string t);
        step();
        tag = t; fill_req = 0; cfg_we = 1; cfg_sel = RW'(sel); cfg_wdata = d;
        step();
        cfg_we = 0;
    endtask

    task automatic fill(input int id, input logic [NW-1:0] v, input logic [NW-1:0] d,
                        input logic [NW-1:0] l, input logic [NW-1:0] u, input string t);
        step();
        tag = t; cfg_we = 0; fill_req = 1; fill_id = RW'(id);
        way_valid = v; way_dirty = d; way_lock = l; way_use = u;
        step();
        fill_req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state seen at the ports
        tag = "R1";
        checks++;
        if (vic_valid || vic_none || vic_wb || vic_way != 0 || vic_use_clr != 0 || cfg_rdata != 0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%0b%0b%0b%0h%0h%0h expected=0",
                     vic_valid, vic_none, vic_wb, vic_way, vic_use_clr, cfg_rdata);
        end
        rst_n = 1'b1;
        step();
        wr(1, 8'hF0, "R2");
        cfg_sel = 3'd1; tag = "R2";
        step();
        wr(7, 8'h3C, "R2");           // folds onto agent mask
        cfg_sel = 3'd4; tag = "R2";
        step();
        wr(1, 8'hFF, "R3");           // rejected
        cfg_sel = 3'd1; tag = "R3";
        step();
        fill(1, 8'hFF, 8'h00, 8'h01, 8'h00, "R5");
        wr(2, 8'h0F, "R4");
        fill(2, 8'hFF, 8'h00, 8'h00, 8'h00, "R4");
        fill(6, 8'hFF, 8'h00, 8'h00, 8'h00, "R4");
        fill(0, 8'hB7, 8'h00, 8'h00, 8'hFF, "R6");
        fill(0, 8'hFF, 8'h00, 8'h00, 8'h07, "R7");
        fill(1, 8'hFF, 8'h00, 8'h02, 8'h0F, "R8");
        fill(1, 8'hFF, 8'hFF, 8'h0F, 8'h00, "R9");
        fill(0, 8'hFF, 8'h04, 8'h00, 8'h03, "R11");
        fill(0, 8'hFB, 8'h04, 8'h00, 8'h03, "R11");
        step(); tag = "R10";
        repeat (3) step();
        for (int k = 0; k < 400; k++) begin
            step();
            tag = "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11";
            cfg_we    = ($urandom_range(0, 5) == 0);
            cfg_sel   = RW'($urandom_range(0, 7));
            cfg_wdata = ($urandom_range(0, 3) == 0) ? 8'hFF : NW'($urandom_range(0, 255));
            cfg_wdata = cfg_wdata | (($urandom_range(0, 1) == 0) ? 8'hAA : 8'h00);
            fill_req  = ($urandom_range(0, 3) != 0);
            fill_id   = RW'($urandom_range(0, 7));
            way_valid = NW'($urandom_range(0, 255)) | 8'hF0;
            way_dirty = NW'($urandom_range(0, 255));
            way_lock  = NW'($urandom_range(0, 255)) & NW'($urandom_range(0, 255));
            way_use   = NW'($urandom_range(0, 255)) | NW'($urandom_range(0, 255));
        end
        step();
        fill_req = 0; cfg_we = 0;
        repeat (3) step();
        finish_run();
    end
endmodule